// File: doc/BRIEF.md
# Log-Structured Page Mapping Unit

This unit sits between a host that reads and writes logical pages and a small flash array. Writes never overwrite in place. Each accepted write goes to the physical page named by a write pointer. The pointer only ever advances, one page per write, whatever logical address the host uses. A logical-to-physical table records where every logical page currently lives. A per-page state array tracks each physical page as erased, holding live data, or holding stale data.

A block is erased only at the moment the write pointer first needs a page inside it. Writes therefore involve no read-modify-write of a whole block. When a logical page is written again, its earlier physical copy becomes stale. Reads go through the table. A read of a logical page that was never written returns zeros and raises a flag. When every physical page has been used, the unit refuses further writes but still serves reads.

The flash commands the unit issues appear on an observation port. A behavioural flash array inside the unit executes them.

Top module: `lsm_ftl`

## Requirements
- R1: After a synchronous active-low reset, every physical page reports state INVALID (encoding 2'b10; page p sits at bits [2p+1:2p] of `page_state`), `wr_ptr` is 0, `full` is 0, and no logical page is mapped.
- R2: An accepted write to logical page N programs its data into physical page `wr_ptr`, records N to that page in the table, reports that page on `rsp_ppn`, and advances `wr_ptr` by one.
- R3: Successive writes program physical pages 0, 1, 2, ... strictly in order, independent of the logical addresses. With 4 pages per block, writes to logical pages 100, 101, 2000 and 2001 land in physical pages 0, 1, 2 and 3.
- R4: A write issues no flash read (op 2'b00). Before the first program into a block whose current page is not ERASED, exactly one erase (op 2'b10) is issued, addressed to that block's first page. No other write erases.
- R5: A page is programmed (op 2'b01) only while its state is ERASED (2'b00), and it becomes VALID (2'b01). An erase puts every page of its block into ERASED.
- R6: Writing a logical page that is already mapped marks its previous physical page INVALID. Later reads return the new data.
- R7: A read of a mapped logical page issues a flash read of the mapped physical page. It returns that page's data, the page number on `rsp_ppn`, and `rsp_unmapped` = 0.
- R8: A read of an unmapped logical page issues no flash command. It returns all-zero data with `rsp_unmapped` = 1.
- R9: When `wr_ptr` equals the page count, `full` is 1. A presented write then sees `req_ready` = 0 and changes nothing. Reads are still accepted and served.
- R10: `rsp_valid` pulses for one cycle. Counting from the first falling clock edge after the accepting rising edge, it is seen at the next falling edge, or one edge later for a write that needs an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this rising edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpn | input | LPN_W | Logical page number |
| req_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Read data (zero when unmapped) |
| rsp_ppn | output | PPN_W | Physical page written or read |
| rsp_unmapped | output | 1 | Read target had no mapping |
| flash_cmd_valid | output | 1 | Flash command issued this cycle |
| flash_cmd_op | output | 2 | 00 read, 01 program, 10 erase |
| flash_cmd_addr | output | PPN_W | Target page (block's first page for erase) |
| flash_cmd_data | output | DATA_W | Program data |
| wr_ptr | output | PTR_W | Next physical page to program |
| full | output | 1 | No free page remains |
| page_state | output | 2*NPAGES | Per-page state, 2 bits per page |

## Verification
A read, or a write whose target block is already erased, completes one cycle after acceptance. A write that opens a block spends one extra cycle on the erase. The bench aligns on the falling edge where the handshake completes and counts falling edges until `rsp_valid` appears, and it checks that count against 1 or 2. A monitor tallies flash commands at falling edges. The per-request tallies and the state vector are read at falling edges where the unit is idle and no command is in flight.

// File: rtl/lsm_pkg.sv
// Shared encodings for the log-structured page mapping unit.
// Assumes: state and command codes are observed on ports, so values are fixed.
package lsm_pkg;
    typedef enum logic [1:0] {
        PG_ERASED  = 2'b00,
        PG_VALID   = 2'b01,
        PG_INVALID = 2'b10
    } pg_state_e;

    typedef enum logic [1:0] {
        FC_READ  = 2'b00,
        FC_PROG  = 2'b01,
        FC_ERASE = 2'b10
    } fcmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WRITE = 2'b01,
        ST_READ  = 2'b10
    } ftl_state_e;
endpackage

// File: rtl/lsm_map_table.sv
// Logical-to-physical table: one valid bit and one physical page per logical page.
// Assumes: a single lookup address shared by read and update; reads are combinational.
module lsm_map_table #(
    parameter int LPN_W = 11,
    parameter int PPN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LPN_W-1:0] lpn,
    input  logic             wr_en,
    input  logic [PPN_W-1:0] wr_ppn,
    output logic             hit,
    output logic [PPN_W-1:0] ppn
);
    localparam int NLP = 1 << LPN_W;

    logic [NLP-1:0]   valid_q;
    logic [PPN_W-1:0] ppn_mem [NLP];

    // Entry valid bits: cleared on reset, set on update.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q      <= '0;
        else if (wr_en) valid_q[lpn] <= 1'b1;
    end

    // Entry page numbers: written on update, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) ppn_mem[lpn] <= wr_ppn;
    end

    assign hit = valid_q[lpn];
    assign ppn = ppn_mem[lpn];

    // R2: an update is visible on the next lookup of the same page.
    p_map_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lpn != $past(lpn)) || (hit && ppn == $past(wr_ppn)));
endmodule

// File: rtl/lsm_page_state.sv
// Per-physical-page state (ERASED / VALID / INVALID) with block erase.
// Assumes: pages per block is a power of two; program and invalidate never
// target the same page in one cycle.
module lsm_page_state
    import lsm_pkg::*;
#(
    parameter int NPAGES = 8,
    parameter int PPB    = 4,
    localparam int PPN_W = $clog2(NPAGES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  erase_en,
    input  logic [PPN_W-1:0]      erase_ppn,
    input  logic                  prog_en,
    input  logic [PPN_W-1:0]      prog_ppn,
    input  logic                  inval_en,
    input  logic [PPN_W-1:0]      inval_ppn,
    output logic [2*NPAGES-1:0]   st_flat
);
    localparam logic [PPN_W-1:0] OFF_MASK = PPN_W'(PPB - 1);

    logic [1:0] st_q [NPAGES];

    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        localparam logic [PPN_W-1:0] BASE = PPN_W'((p / PPB) * PPB);
        logic in_blk;
        assign in_blk = (erase_ppn & ~OFF_MASK) == BASE;

        // Page state update: erase, then program, then invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  st_q[p] <= PG_INVALID;
            else if (erase_en && in_blk)                 st_q[p] <= PG_ERASED;
            else if (prog_en && prog_ppn == PPN_W'(p))   st_q[p] <= PG_VALID;
            else if (inval_en && inval_ppn == PPN_W'(p)) st_q[p] <= PG_INVALID;
        end

        assign st_flat[2*p +: 2] = st_q[p];
    end

    // R5: only erased pages are programmed.
    p_prog_erased_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> st_flat[2*int'(prog_ppn) +: 2] == PG_ERASED);

    // R6: only live pages are turned into garbage.
    p_inval_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inval_en |-> st_flat[2*int'(inval_ppn) +: 2] == PG_VALID);

    // R1: the first cycle out of reset shows every page INVALID.
    p_reset_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> st_flat == {NPAGES{2'b10}});
endmodule

// File: rtl/lsm_flash_array.sv
// Behavioural flash array: page read, page program, block erase (to all ones).
// Assumes: commands arrive one per cycle; read data is combinational on the address.
module lsm_flash_array
    import lsm_pkg::*;
#(
    parameter int NPAGES = 8,
    parameter int PPB    = 4,
    parameter int DATA_W = 16,
    localparam int PPN_W = $clog2(NPAGES)
) (
    input  logic              clk,
    input  logic              cmd_valid,
    input  fcmd_e             cmd_op,
    input  logic [PPN_W-1:0]  cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [PPN_W-1:0] OFF_MASK = PPN_W'(PPB - 1);

    logic [DATA_W-1:0] mem [NPAGES];

    for (genvar p = 0; p < NPAGES; p++) begin : g_cell
        localparam logic [PPN_W-1:0] BASE = PPN_W'((p / PPB) * PPB);

        // Cell contents: erase sets ones, program stores data.
        always_ff @(posedge clk) begin
            if (cmd_valid && cmd_op == FC_ERASE && (cmd_addr & ~OFF_MASK) == BASE)
                mem[p] <= '1;
            else if (cmd_valid && cmd_op == FC_PROG && cmd_addr == PPN_W'(p))
                mem[p] <= cmd_data;
        end
    end

    assign rd_data = mem[cmd_addr];
endmodule

// File: rtl/lsm_ftl.sv
// Log-structured page mapping unit (top). Accepts one host request at a time,
// appends writes at a monotonic write pointer, erasing a block on first entry,
// and translates reads through the mapping table.
// Assumes: PAGES_PER_BLK is a power of two; no reclamation of stale pages.
module lsm_ftl
    import lsm_pkg::*;
#(
    parameter int LPN_W         = 11,
    parameter int DATA_W        = 16,
    parameter int PAGES_PER_BLK = 4,
    parameter int NUM_BLKS      = 2,
    localparam int NPAGES       = PAGES_PER_BLK * NUM_BLKS,
    localparam int PPN_W        = $clog2(NPAGES),
    localparam int PTR_W        = PPN_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [LPN_W-1:0]    req_lpn,
    input  logic [DATA_W-1:0]   req_data,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic [PPN_W-1:0]    rsp_ppn,
    output logic                rsp_unmapped,
    output logic                flash_cmd_valid,
    output logic [1:0]          flash_cmd_op,
    output logic [PPN_W-1:0]    flash_cmd_addr,
    output logic [DATA_W-1:0]   flash_cmd_data,
    output logic [PTR_W-1:0]    wr_ptr,
    output logic                full,
    output logic [2*NPAGES-1:0] page_state
);
    localparam logic [PPN_W-1:0] OFF_MASK = PPN_W'(PAGES_PER_BLK - 1);

    ftl_state_e        st_q;
    logic [LPN_W-1:0]  lpn_q;
    logic [DATA_W-1:0] data_q;
    logic [PTR_W-1:0]  wp_q;
    logic [PPN_W-1:0]  wp_ppn;
    logic              map_hit;
    logic [PPN_W-1:0]  map_ppn;
    logic              need_erase;
    logic              prog_fire;
    logic              rd_fire;
    logic              accept;
    fcmd_e             cmd_op;
    logic [DATA_W-1:0] fl_rd_data;

    assign wp_ppn     = wp_q[PPN_W-1:0];
    assign full       = wp_q == PTR_W'(NPAGES);
    assign wr_ptr     = wp_q;
    assign req_ready  = (st_q == ST_IDLE) && !(full && req_write);
    assign accept     = req_valid && req_ready;
    assign need_erase = page_state[2*int'(wp_ppn) +: 2] != PG_ERASED;
    assign prog_fire  = (st_q == ST_WRITE) && !need_erase;
    assign rd_fire    = st_q == ST_READ;

    // Flash command selection for the current cycle.
    always_comb begin
        flash_cmd_valid = 1'b0;
        cmd_op          = FC_READ;
        flash_cmd_addr  = '0;
        if (st_q == ST_WRITE) begin
            flash_cmd_valid = 1'b1;
            cmd_op          = need_erase ? FC_ERASE : FC_PROG;
            flash_cmd_addr  = need_erase ? (wp_ppn & ~OFF_MASK) : wp_ppn;
        end else if (st_q == ST_READ && map_hit) begin
            flash_cmd_valid = 1'b1;
            cmd_op          = FC_READ;
            flash_cmd_addr  = map_ppn;
        end
    end

    assign flash_cmd_op   = cmd_op;
    assign flash_cmd_data = data_q;

    // Request sequencer: capture on accept, return to idle on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:  if (accept) st_q <= req_write ? ST_WRITE : ST_READ;
                ST_WRITE: if (prog_fire) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Request payload capture.
    always_ff @(posedge clk) begin
        if (accept) begin
            lpn_q  <= req_lpn;
            data_q <= req_data;
        end
    end

    // Write pointer: advances once per program.
    always_ff @(posedge clk) begin
        if (!rst_n)         wp_q <= '0;
        else if (prog_fire) wp_q <= wp_q + PTR_W'(1);
    end

    // Response register: one-cycle pulse with result fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_ppn      <= '0;
            rsp_unmapped <= 1'b0;
        end else begin
            rsp_valid <= prog_fire || rd_fire;
            if (prog_fire) begin
                rsp_data     <= data_q;
                rsp_ppn      <= wp_ppn;
                rsp_unmapped <= 1'b0;
            end else if (rd_fire) begin
                rsp_data     <= map_hit ? fl_rd_data : '0;
                rsp_ppn      <= map_hit ? map_ppn : '0;
                rsp_unmapped <= !map_hit;
            end
        end
    end

    lsm_map_table #(.LPN_W(LPN_W), .PPN_W(PPN_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .lpn    (lpn_q),
        .wr_en  (prog_fire),
        .wr_ppn (wp_ppn),
        .hit    (map_hit),
        .ppn    (map_ppn)
    );

    lsm_page_state #(.NPAGES(NPAGES), .PPB(PAGES_PER_BLK)) u_pst (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_en  ((st_q == ST_WRITE) && need_erase),
        .erase_ppn (wp_ppn),
        .prog_en   (prog_fire),
        .prog_ppn  (wp_ppn),
        .inval_en  (prog_fire && map_hit),
        .inval_ppn (map_ppn),
        .st_flat   (page_state)
    );

    lsm_flash_array #(.NPAGES(NPAGES), .PPB(PAGES_PER_BLK), .DATA_W(DATA_W)) u_flash (
        .clk       (clk),
        .cmd_valid (flash_cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (flash_cmd_addr),
        .cmd_data  (data_q),
        .rd_data   (fl_rd_data)
    );

    // R3: the write pointer moves only forward, one page at a time.
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != $past(wr_ptr)) |-> (wr_ptr == $past(wr_ptr) + PTR_W'(1)));

    // R2: a program command is followed by a write response.
    p_prog_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd_valid && flash_cmd_op == 2'b01) |=> (rsp_valid && !rsp_unmapped));

    // R4: an erase targets a block's first page and is followed by a program.
    p_erase_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd_valid && flash_cmd_op == 2'b10) |-> (flash_cmd_addr & OFF_MASK) == '0);
    p_erase_then_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd_valid && flash_cmd_op == 2'b10) |=> (flash_cmd_valid && flash_cmd_op == 2'b01));

    // R8: an unmapped read returns zeros.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_unmapped) |-> rsp_data == '0);

    // R9: a full unit accepts no write.
    p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && req_write) |-> !req_ready);

    // R10: responses are single-cycle pulses.
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/lsm_ftl_bench.sv
// Directed bench for the log-structured page mapping unit.
module lsm_ftl_bench;
    localparam int LPN_W  = 11;
    localparam int DATA_W = 16;
    localparam int NPAGES = 8;
    localparam int PPN_W  = 3;
    localparam int PTR_W  = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [LPN_W-1:0]    req_lpn = '0;
    logic [DATA_W-1:0]   req_data = '0;
    logic                rsp_valid;
    logic [DATA_W-1:0]   rsp_data;
    logic [PPN_W-1:0]    rsp_ppn;
    logic                rsp_unmapped;
    logic                flash_cmd_valid;
    logic [1:0]          flash_cmd_op;
    logic [PPN_W-1:0]    flash_cmd_addr;
    logic [DATA_W-1:0]   flash_cmd_data;
    logic [PTR_W-1:0]    wr_ptr;
    logic                full;
    logic [2*NPAGES-1:0] page_state;

    int tests = 0;
    int fails = 0;
    int mon_rd = 0, mon_pg = 0, mon_er = 0;
    logic [PPN_W-1:0] mon_er_addr = '0;
    logic [PPN_W-1:0] mon_rd_addr = '0;

    always #5 clk = ~clk;

    lsm_ftl u_lsm_ftl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_lpn(req_lpn), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ppn(rsp_ppn),
        .rsp_unmapped(rsp_unmapped), .flash_cmd_valid(flash_cmd_valid),
        .flash_cmd_op(flash_cmd_op), .flash_cmd_addr(flash_cmd_addr),
        .flash_cmd_data(flash_cmd_data), .wr_ptr(wr_ptr), .full(full),
        .page_state(page_state)
    );

    // Flash command monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && flash_cmd_valid) begin
            case (flash_cmd_op)
                2'b00:   begin mon_rd++; mon_rd_addr = flash_cmd_addr; end
                2'b01:   mon_pg++;
                default: begin mon_er++; mon_er_addr = flash_cmd_addr; end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request: handshake, then wait for the response; returns latency and command counts.
    task automatic do_req(input bit wr, input logic [LPN_W-1:0] lpn, input logic [DATA_W-1:0] d,
                          output int lat, output int n_rd, output int n_pg, output int n_er);
        int rd0, pg0, er0;
        rd0 = mon_rd; pg0 = mon_pg; er0 = mon_er;
        req_valid = 1'b1; req_write = wr; req_lpn = lpn; req_data = d;
        #1;
        for (int w = 0; w < 50 && !req_ready; w++) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        for (int w = 0; w < 50; w++) begin
            @(negedge clk);
            lat++;
            if (rsp_valid) break;
        end
        n_rd = mon_rd - rd0; n_pg = mon_pg - pg0; n_er = mon_er - er0;
    endtask

    task automatic t_reset_state();
        int lat, nr, np, ne;
        chk(page_state == 16'hAAAA, "R1 page_state", 32'(page_state), 32'hAAAA);
        chk(wr_ptr == 0 && !full, "R1 wr_ptr/full", {wr_ptr, 3'b0, full}, 0);
        do_req(1'b0, 11'd100, '0, lat, nr, np, ne);
        chk(rsp_unmapped && rsp_data == 0, "R8 unmapped after reset", {rsp_unmapped, rsp_data}, 32'h10000);
        chk(nr + np + ne == 0, "R8 no flash command", nr + np + ne, 0);
        chk(lat == 1, "R10 read latency", lat, 1);
    endtask

    task automatic t_example_writes();
        int lat, nr, np, ne;
        logic [LPN_W-1:0] lpns [4] = '{11'd100, 11'd101, 11'd2000, 11'd2001};
        for (int i = 0; i < 4; i++) begin
            do_req(1'b1, lpns[i], 16'hA000 + 16'(i), lat, nr, np, ne);
            chk(rsp_ppn == PPN_W'(i), "R3 sequential page", rsp_ppn, i);
            chk(np == 1 && nr == 0, "R4 one program no read", {np, nr}, 1);
            chk(ne == (i == 0 ? 1 : 0), "R4 erase count", ne, (i == 0 ? 1 : 0));
            chk(lat == (i == 0 ? 2 : 1), "R10 write latency", lat, (i == 0 ? 2 : 1));
        end
        chk(mon_er_addr == 0, "R4 erase address", mon_er_addr, 0);
        chk(wr_ptr == 4, "R2 wr_ptr advance", wr_ptr, 4);
        chk(page_state == 16'hAA55, "R5 block0 valid", 32'(page_state), 32'hAA55);
        do_req(1'b0, 11'd2000, '0, lat, nr, np, ne);
        chk(rsp_data == 16'hA002 && rsp_ppn == 2 && !rsp_unmapped, "R7 read 2000", {rsp_ppn, rsp_data}, {3'd2, 16'hA002});
        chk(nr == 1 && mon_rd_addr == 2, "R7 flash read address", mon_rd_addr, 2);
    endtask

    task automatic t_overwrite();
        int lat, nr, np, ne;
        do_req(1'b1, 11'd100, 16'hB100, lat, nr, np, ne);
        chk(rsp_ppn == 4, "R3 overwrite page", rsp_ppn, 4);
        chk(ne == 1 && mon_er_addr == 4, "R4 erase block1", mon_er_addr, 4);
        chk(lat == 2, "R10 erase write latency", lat, 2);
        chk(page_state == 16'h0156, "R6 old page invalid", 32'(page_state), 32'h0156);
        do_req(1'b0, 11'd100, '0, lat, nr, np, ne);
        chk(rsp_data == 16'hB100 && rsp_ppn == 4, "R6 read new data", {rsp_ppn, rsp_data}, {3'd4, 16'hB100});
    endtask

    task automatic t_fill_and_full();
        int lat, nr, np, ne;
        for (int i = 0; i < 3; i++) begin
            do_req(1'b1, 11'd7 + 11'(i), 16'hC000 + 16'(i), lat, nr, np, ne);
            chk(rsp_ppn == PPN_W'(5 + i) && ne == 0, "R3 fill page", {rsp_ppn, 4'(ne)}, (5 + i) << 4);
        end
        chk(full && wr_ptr == 8, "R9 full flag", {full, wr_ptr}, 5'h18);
        chk(page_state == 16'h5556, "R5 all programmed", 32'(page_state), 32'h5556);
        req_valid = 1'b1; req_write = 1'b1; req_lpn = 11'd101; req_data = 16'hDEAD;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!req_ready, "R9 ready low when full", req_ready, 0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(wr_ptr == 8 && page_state == 16'h5556 && !rsp_valid, "R9 nothing changed", 32'(page_state), 32'h5556);
        do_req(1'b0, 11'd101, '0, lat, nr, np, ne);
        chk(rsp_data == 16'hA001 && rsp_ppn == 1, "R9 read while full", {rsp_ppn, rsp_data}, {3'd1, 16'hA001});
    endtask

    task automatic t_unmapped_read();
        int lat, nr, np, ne;
        do_req(1'b0, 11'd0, '0, lat, nr, np, ne);
        chk(rsp_unmapped && rsp_data == 0 && nr == 0, "R8 unmapped lpn 0", {rsp_unmapped, rsp_data}, 32'h10000);
        do_req(1'b0, 11'd2001, '0, lat, nr, np, ne);
        chk(!rsp_unmapped && rsp_data == 16'hA003 && rsp_ppn == 3, "R7 read 2001", {rsp_ppn, rsp_data}, {3'd3, 16'hA003});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_example_writes();
        t_overwrite();
        t_fill_and_full();
        t_unmapped_read();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule